// File: doc/BRIEF.md
# Emergency Pin Fault Detector

This block monitors three active-low emergency request pins and latches a sticky fault flag for each one. Each pin has its own 2-bit detection mode. The pin can be watched for a falling edge, or it can be sampled for a sustained low level at one of three divided clock rates. Any latched flag drives a combined high-impedance request, which the surrounding port logic uses to release its output drivers. When the interrupt enable is set, any latched flag also drives an interrupt request.

Software sees the block through one 16-bit control/status word on a simple synchronous read/write port. A flag can be cleared only by a handshake: software reads the flag as 1, then writes 0 to it. The detection modes can be written only once after reset, so a stray write cannot disarm the protection later. In the level modes, a flag also refuses to clear until the pin has been sampled high again.

Top module: `pfd_guard`

## Requirements
- R1: After reset every register bit is 0, so flag, irq and hiz_req are 0 and a read returns 0x0000.
- R2: The word layout is as follows. Flags for pins 2, 1 and 0 are at bits 15, 13 and 12. The interrupt enable is bit 8. The mode fields for pins 2, 1 and 0 are at bits 7:6, 3:2 and 1:0. Reserved bits 14, 11:9 and 5:4 read 0 and ignore writes.
- R3: The first write after reset loads all mode fields. Every later write leaves the mode fields unchanged, while the interrupt enable stays writable.
- R4: Mode 00 sets the pin's flag on a falling edge of the pin after a two-flop synchronizer.
- R5: Modes 01, 10 and 11 set the flag after 16 consecutive low samples taken at clock/8, clock/16 and clock/128 respectively. A high sample restarts the count, so a shorter low run sets nothing.
- R6: A flag clears only when 0 is written to its bit after a read returned it as 1. Writing 1 has no effect. Writing 0 without a prior read of 1 has no effect. Any write ends the armed state, so the next clear needs a fresh read.
- R7: In a level mode, the clear handshake has no effect until the pin has been sampled high at the selected rate since the flag was set.
- R8: If a new detection occurs in the same cycle as a valid clear, the flag stays set.
- R9: irq is 1 exactly when the interrupt enable is 1 and any flag is 1. hiz_req is the OR of all flags.
- R10: A read (reg_en=1, reg_we=0) updates reg_rdata at the next clock edge, and reg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 3 | Active-low emergency request pins 0..2 |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| flag | output | 3 | Latched fault flags, bit i for pin i |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | Combined high-impedance request |

## Verification
Each pin in edge mode gets a short low pulse in turn, which shows that exactly one flag bit and the correct word bit respond to each pin. In the level modes, low runs are held just short of and just past the 16-sample window at all three rates, which separates the three divider rates from one another and from a missing restart of the count. The clear handshake is tried in several forms: writing 0 unarmed, writing 1 after a read, re-using a stale read, clearing while the pin is still low, and clearing in the same cycle as a fresh edge. Together these pin down the ordering among read, write, resample and detection.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NUM_PINS = 3;
  localparam int WORD_W   = 16;
  localparam int IE_POS   = 8;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_LVL_A = 2'b01,
    MODE_LVL_B = 2'b10,
    MODE_LVL_C = 2'b11
  } pfd_mode_e;

  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return 12;
      1:       return 13;
      default: return 15;
    endcase
  endfunction

  function automatic int mode_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/pfd_prescaler.sv
module pfd_prescaler #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick_lvl
);
  localparam int CW = $clog2(DIV_C);
  localparam int AW = $clog2(DIV_A);
  localparam int BW = $clog2(DIV_B);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    tick_lvl[0] = &cnt_q[AW-1:0];
    tick_lvl[1] = &cnt_q[BW-1:0];
    tick_lvl[2] = &cnt_q;
  end
endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
  import pfd_pkg::*;
#(
  parameter int LOW_RUN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic [1:0] mode,
  input  logic [2:0] tick_lvl,
  input  logic       rd_hit,
  input  logic       wr_hit,
  input  logic       wr_val,
  output logic       flag
);
  localparam int RW = $clog2(LOW_RUN + 1);

  logic          sync1_q, sync2_q, prev_q;
  logic [RW-1:0] run_q;
  logic          hi_seen_q, armed_q, flag_q;
  logic          edge_mode, smp, fall, lvl_hit, detect, clr_ok;

  always_comb begin
    edge_mode = (pfd_mode_e'(mode) == MODE_EDGE);
    case (pfd_mode_e'(mode))
      MODE_LVL_A: smp = tick_lvl[0];
      MODE_LVL_B: smp = tick_lvl[1];
      MODE_LVL_C: smp = tick_lvl[2];
      default:    smp = 1'b0;
    endcase
    fall    = prev_q & ~sync2_q;
    lvl_hit = smp & ~sync2_q & (run_q == RW'(LOW_RUN - 1));
    detect  = edge_mode ? fall : lvl_hit;
    clr_ok  = wr_hit & ~wr_val & armed_q & (edge_mode | hi_seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b1;
      sync2_q   <= 1'b1;
      prev_q    <= 1'b1;
      run_q     <= '0;
      hi_seen_q <= 1'b0;
      armed_q   <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (smp) begin
        if (sync2_q)                      run_q <= '0;
        else if (run_q != RW'(LOW_RUN))   run_q <= run_q + 1'b1;
      end
      if (detect)             hi_seen_q <= 1'b0;
      else if (smp & sync2_q) hi_seen_q <= 1'b1;
      if (rd_hit & flag_q)    armed_q <= 1'b1;
      else if (wr_hit)        armed_q <= 1'b0;
      if (detect)             flag_q <= 1'b1;
      else if (clr_ok)        flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/pfd_guard.sv
module pfd_guard
  import pfd_pkg::*;
#(
  parameter int DIV_A   = 8,
  parameter int DIV_B   = 16,
  parameter int DIV_C   = 128,
  parameter int LOW_RUN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] flag,
  output logic                irq,
  output logic                hiz_req
);
  localparam int MW = 2 * NUM_PINS;

  logic              wr_hit, rd_hit;
  logic              ie_q, mode_lock_q;
  logic [MW-1:0]     mode_q, mode_wr;
  logic [WORD_W-1:0] rd_word, rdata_q;
  logic [2:0]        tick_lvl;

  assign wr_hit = reg_en & reg_we;
  assign rd_hit = reg_en & ~reg_we;

  pfd_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) presc_i (
    .clk(clk), .rst_n(rst_n), .tick_lvl(tick_lvl)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ch
    pfd_channel #(.LOW_RUN(LOW_RUN)) ch_i (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n[g]),
      .mode(mode_q[2*g +: 2]), .tick_lvl(tick_lvl),
      .rd_hit(rd_hit), .wr_hit(wr_hit),
      .wr_val(reg_wdata[flag_pos(g)]), .flag(flag[g])
    );
  end

  always_comb begin
    rd_word = '0;
    mode_wr = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      rd_word[flag_pos(i)]      = flag[i];
      rd_word[mode_pos(i) +: 2] = mode_q[2*i +: 2];
      mode_wr[2*i +: 2]         = reg_wdata[mode_pos(i) +: 2];
    end
    rd_word[IE_POS] = ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= 1'b0;
      mode_q      <= '0;
      mode_lock_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (wr_hit) begin
        ie_q <= reg_wdata[IE_POS];
        if (!mode_lock_q) begin
          mode_q      <= mode_wr;
          mode_lock_q <= 1'b1;
        end
      end
      if (rd_hit) rdata_q <= rd_word;
    end
  end

  assign reg_rdata = rdata_q;
  assign hiz_req   = |flag;
  assign irq       = ie_q & hiz_req;
endmodule

// File: rtl/pfd_guard_chk.sv
module pfd_guard_chk
  import pfd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_en,
  input logic                reg_we,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic [WORD_W-1:0]   reg_rdata,
  input logic [NUM_PINS-1:0] flag,
  input logic                irq,
  input logic                hiz_req,
  input logic [2*NUM_PINS-1:0] mode_q
);
  logic wrote_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wrote_q <= 1'b0;
    else if (reg_en & reg_we) wrote_q <= 1'b1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h4E30) == 16'h0000); // R2

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_q |=> $stable(mode_q)); // R3

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hiz_req); // R9

  AST_HIZ_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req == ($countones(flag) != 0)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en & ~reg_we) |=> $stable(reg_rdata)); // R10

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_f
    AST_CLEAR_NEEDS_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !(reg_en && reg_we && !reg_wdata[flag_pos(g)])) |=> flag[g]); // R6
  end
endmodule

bind pfd_guard pfd_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag(flag),
  .irq(irq), .hiz_req(hiz_req), .mode_q(mode_q)
);

// File: tb/pfd_guard_tb.sv
module pfd_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pin_n = 3'b111;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  flag;
  logic        irq, hiz_req;
  int n_chk = 0, n_err = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  pfd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag(flag), .irq(irq), .hiz_req(hiz_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_n = 3'b111; reg_en = 1'b0; reg_we = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic wr(input logic [15:0] v);
    reg_en = 1'b1; reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    reg_en = 1'b1; reg_we = 1'b0;
    @(negedge clk);
    reg_en = 1'b0;
    v = reg_rdata;
  endtask

  function automatic int fpos(input int i);
    return (i == 2) ? 15 : 12 + i;
  endfunction

  task automatic finish_up();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 outputs", {12'h0, flag, irq}, 16'h0);
    rd(rv); chk("R1 read", rv, 16'h0000);
    // R3 first write loads modes (edge) and ie, later write keeps modes
    wr(16'h0100); rd(rv); chk("R3 first write", rv, 16'h0100);
    wr(16'h01C9); rd(rv); chk("R3 locked modes", rv, 16'h0100);
    // R2 reserved bits ignore writes, flag writes of 1 do nothing
    wr(16'hFFFF); rd(rv); chk("R2 reserved", rv, 16'h0100);
    chk("R10 rdata held", reg_rdata, 16'h0100);

    for (int i = 0; i < 3; i++) begin
      pin_n[i] = 1'b0; wait_cyc(3); pin_n[i] = 1'b1; wait_cyc(4);
      chk("R4 edge flag", {13'h0, flag}, 16'(1 << i));
      chk("R9 irq hiz", {14'h0, irq, hiz_req}, 16'h3);
      wr(16'h0100);
      chk("R6 unarmed write0", {13'h0, flag}, 16'(1 << i));
      rd(rv); chk("R2 flag position", rv, 16'h0100 | 16'(1 << fpos(i)));
      wr(16'h0100 | 16'(1 << fpos(i)));
      chk("R6 write1 no clear", {13'h0, flag}, 16'(1 << i));
      wr(16'h0100);
      chk("R6 stale read", {13'h0, flag}, 16'(1 << i));
      rd(rv); wr(16'h0100);
      chk("R6 handshake clear", {13'h0, flag}, 16'h0);
    end

    // R9 irq masked by enable
    pin_n[1] = 1'b0; wait_cyc(3); pin_n[1] = 1'b1; wait_cyc(4);
    wr(16'h0000);
    chk("R9 irq masked", {14'h0, irq, hiz_req}, 16'h1);
    rd(rv); wr(16'h0100);
    chk("R9 cleared", {14'h0, irq, hiz_req}, 16'h0);

    // R8 detection in same cycle as valid clear wins
    pin_n[0] = 1'b0; wait_cyc(3); pin_n[0] = 1'b1; wait_cyc(4);
    rd(rv);
    pin_n[0] = 1'b0;
    wait_cyc(2);
    wr(16'h0100);
    chk("R8 detect wins", {13'h0, flag}, 16'h1);
    pin_n[0] = 1'b1; wait_cyc(3);
    rd(rv); wr(16'h0100);
    chk("R8 later clear", {13'h0, flag}, 16'h0);

    // level modes: pin0 /8, pin1 /16, pin2 /128
    do_reset();
    wr(16'h01C9); wr(16'h0100); rd(rv); chk("R3 level modes locked", rv, 16'h01C9);
    pin_n[0] = 1'b0; wait_cyc(60); pin_n[0] = 1'b1; wait_cyc(20);
    chk("R5 short run", {13'h0, flag}, 16'h0);
    pin_n[0] = 1'b0; wait_cyc(100);
    chk("R5 div8 not yet", {13'h0, flag}, 16'h0);
    wait_cyc(40);
    chk("R5 div8 set", {13'h0, flag}, 16'h1);
    rd(rv); wr(16'h0100);
    chk("R7 low pin blocks clear", {13'h0, flag}, 16'h1);
    pin_n[0] = 1'b1; wait_cyc(20);
    rd(rv); wr(16'h0100);
    chk("R7 clear after high", {13'h0, flag}, 16'h0);

    pin_n[1] = 1'b0; wait_cyc(200);
    chk("R5 div16 not yet", {13'h0, flag}, 16'h0);
    wait_cyc(80);
    chk("R5 div16 set", {13'h0, flag}, 16'h2);
    pin_n[1] = 1'b1;

    pin_n[2] = 1'b0; wait_cyc(1900);
    chk("R5 div128 not yet", {13'h0, flag}, 16'h2);
    wait_cyc(200);
    chk("R5 div128 set", {13'h0, flag}, 16'h6);
    pin_n[2] = 1'b1; wait_cyc(300);
    rd(rv); chk("R2 level word", rv, 16'hA1C9);
    wr(16'h0100);
    chk("R7 both cleared", {13'h0, flag}, 16'h0);

    finish_up();
  end
endmodule